// File: doc/BRIEF.md
# Thermal Clock Throttle Governor

This block holds the clock multiplier of a compute engine together with a "cool ceiling" that limits how high the multiplier may be set. The output frequency is twice the multiplier, in MHz. Temperature samples arrive with a valid strobe, and each sample is compared with a target temperature and a hysteresis band. If the temperature rises above the band, the multiplier steps down by one and the ceiling is pulled down to the new multiplier. A hold-off interval, counted in clock cycles, limits how often these reductions can happen.

When the temperature is below the target, the ceiling recovers. It returns straight to the absolute maximum if the temperature is below the band. Inside the band it climbs by one step, and only while the multiplier is sitting at the ceiling. A higher-level tuner can request a multiplier at any time. The request is clamped between the minimum multiplier and the current ceiling. Each change of the active multiplier raises a one-cycle pulse so that the clock generator can reprogram.

Top module: `thermal_governor`

## Requirements
- R1: After synchronous reset the multiplier is 95 (190 MHz), the ceiling is 125 (250 MHz), the change pulse is low and the hold-off has expired.
- R2: A valid sample with temperature strictly greater than target plus hysteresis, taken while the hold-off has expired, lowers the multiplier by one, sets the ceiling to the new multiplier and restarts the hold-off. The new values appear after the clock edge that takes the sample.
- R3: After a reduction taken at clock edge e, hot samples at edges e+1 through e+H, where H is the hold-off value at edge e, change nothing. A hot sample at edge e+H+1 or later reduces again.
- R4: The multiplier never goes below 1. A reduction at multiplier 1 keeps the multiplier at 1 and sets the ceiling to 1.
- R5: A valid sample strictly below target minus hysteresis, while the ceiling is below the absolute-maximum input, sets the ceiling to the absolute maximum.
- R6: A valid sample at or above target minus hysteresis and strictly below target, while the ceiling is below the absolute maximum, raises the ceiling by one only if the multiplier equals the ceiling. Otherwise the ceiling is unchanged.
- R7: A valid sample from target up to and including target plus hysteresis leaves the multiplier and the ceiling unchanged.
- R8: When the sample-valid strobe is low, the temperature input has no effect on the multiplier or the ceiling.
- R9: A request in a cycle without a valid sample sets the multiplier to the requested value clamped to the range from 1 to the current ceiling.
- R10: A request in the same cycle as a valid sample is dropped. The sample alone decides the next state.
- R11: The change pulse is high for exactly the one cycle after an edge at which the multiplier changed, and is low otherwise.
- R12: The multiplier never exceeds the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Temperature sample strobe |
| sample_temp | input | TEMP_W | Signed temperature, whole degrees |
| target_temp | input | TEMP_W | Signed target temperature |
| hysteresis | input | TEMP_W-1 | Unsigned half-width of the band |
| abs_max | input | MULT_W | Absolute maximum multiplier |
| holdoff_cycles | input | HOLD_W | Minimum spacing between reductions, in cycles |
| req_valid | input | 1 | Multiplier request strobe |
| req_mult | input | MULT_W | Requested multiplier |
| mult_out | output | MULT_W | Active multiplier |
| ceiling_out | output | MULT_W | Current cool ceiling |
| mult_changed | output | 1 | One-cycle pulse after a multiplier change |

## Verification
The multiplier and the ceiling are both visible at the ports, so a wrong update of either shows up on the cycle after the edge that caused it. A fault in the hold-off counter cannot be seen directly. It becomes visible when a hot sample is accepted too early, which makes a reduction appear one or more cycles before it is due. A hot sample can also be ignored too late, which makes an expected reduction go missing. The bench therefore places hot samples on both sides of the hold-off boundary. A wrong zone decision shows up on the first sample in that zone through its effect on the ceiling.

// File: rtl/thermal_gov_pkg.sv
package thermal_gov_pkg;

    // Position of a temperature sample relative to the target band
    typedef enum logic [1:0] {
        ZONE_NEUTRAL = 2'd0,   // target .. target+hyst
        ZONE_HOT     = 2'd1,   // above target+hyst
        ZONE_BAND    = 2'd2,   // target-hyst .. below target
        ZONE_COLD    = 2'd3    // below target-hyst
    } temp_zone_e;

    localparam int GOV_MULT_W   = 8;
    localparam int GOV_TEMP_W   = 10;
    localparam int GOV_HOLD_W   = 16;
    localparam int GOV_MIN_MULT = 1;
    localparam int GOV_DEF_MULT = 95;
    localparam int GOV_MAX_MULT = 125;

endpackage

// File: rtl/thermal_zone_classifier.sv
module thermal_zone_classifier
    import thermal_gov_pkg::*;
#(
    parameter int TEMP_W = GOV_TEMP_W
) (
    input  logic signed [TEMP_W-1:0] temp,
    input  logic signed [TEMP_W-1:0] target,
    input  logic        [TEMP_W-2:0] hyst,
    output temp_zone_e               zone
);
    localparam int EW = TEMP_W + 2;

    logic signed [EW-1:0] t_x, tg_x, h_x, hi_x, lo_x;

    always_comb begin
        t_x  = {{2{temp[TEMP_W-1]}}, temp};
        tg_x = {{2{target[TEMP_W-1]}}, target};
        h_x  = $signed({3'b000, hyst});
        hi_x = tg_x + h_x;
        lo_x = tg_x - h_x;
        if (t_x > hi_x)
            zone = ZONE_HOT;
        else if (t_x >= tg_x)
            zone = ZONE_NEUTRAL;
        else if (t_x >= lo_x)
            zone = ZONE_BAND;
        else
            zone = ZONE_COLD;
    end

endmodule

// File: rtl/thermal_holdoff_timer.sv
module thermal_holdoff_timer
    import thermal_gov_pkg::*;
#(
    parameter int HOLD_W = GOV_HOLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              expired
);
    logic [HOLD_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (load)
            remain_q <= load_val;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/thermal_governor.sv
module thermal_governor
    import thermal_gov_pkg::*;
#(
    parameter int MULT_W   = GOV_MULT_W,
    parameter int TEMP_W   = GOV_TEMP_W,
    parameter int HOLD_W   = GOV_HOLD_W,
    parameter int MIN_MULT = GOV_MIN_MULT,
    parameter int DEF_MULT = GOV_DEF_MULT,
    parameter int MAX_MULT = GOV_MAX_MULT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_valid,
    input  logic signed [TEMP_W-1:0] sample_temp,
    input  logic signed [TEMP_W-1:0] target_temp,
    input  logic        [TEMP_W-2:0] hysteresis,
    input  logic        [MULT_W-1:0] abs_max,
    input  logic        [HOLD_W-1:0] holdoff_cycles,
    input  logic                     req_valid,
    input  logic        [MULT_W-1:0] req_mult,
    output logic        [MULT_W-1:0] mult_out,
    output logic        [MULT_W-1:0] ceiling_out,
    output logic                     mult_changed
);
    localparam logic [MULT_W-1:0] MIN_M = MULT_W'(MIN_MULT);
    localparam logic [MULT_W-1:0] DEF_M = MULT_W'(DEF_MULT);
    localparam logic [MULT_W-1:0] MAX_M = MULT_W'(MAX_MULT);

    temp_zone_e        zone;
    logic              hold_expired;
    logic              reduce;
    logic [MULT_W-1:0] mult_q, ceil_q, mult_n, ceil_n;
    logic              changed_q;

    thermal_zone_classifier #(.TEMP_W(TEMP_W)) u_zone (
        .temp   (sample_temp),
        .target (target_temp),
        .hyst   (hysteresis),
        .zone   (zone)
    );

    thermal_holdoff_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (reduce),
        .load_val (holdoff_cycles),
        .expired  (hold_expired)
    );

    always_comb begin
        mult_n = mult_q;
        ceil_n = ceil_q;
        reduce = 1'b0;
        if (sample_valid) begin
            unique case (zone)
                ZONE_HOT: begin
                    if (hold_expired) begin
                        reduce = 1'b1;
                        if (mult_q > MIN_M)
                            mult_n = mult_q - 1'b1;
                        ceil_n = mult_n;
                    end
                end
                ZONE_COLD: begin
                    if (ceil_q < abs_max)
                        ceil_n = abs_max;
                end
                ZONE_BAND: begin
                    if ((ceil_q < abs_max) && (mult_q == ceil_q))
                        ceil_n = ceil_q + 1'b1;
                end
                default: ;
            endcase
        end else if (req_valid) begin
            if (req_mult < MIN_M)
                mult_n = MIN_M;
            else if (req_mult > ceil_q)
                mult_n = ceil_q;
            else
                mult_n = req_mult;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_q    <= DEF_M;
            ceil_q    <= MAX_M;
            changed_q <= 1'b0;
        end else begin
            mult_q    <= mult_n;
            ceil_q    <= ceil_n;
            changed_q <= (mult_n != mult_q);
        end
    end

    assign mult_out     = mult_q;
    assign ceiling_out  = ceil_q;
    assign mult_changed = changed_q;

    assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
        mult_q >= MIN_M);

    assert_under_ceiling_R12: assert property (@(posedge clk) disable iff (rst)
        mult_q <= ceil_q);

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && zone == ZONE_HOT && hold_expired && mult_q > MIN_M)
        |=> (mult_q == $past(mult_q) - 1'b1) && (ceil_q == mult_q));

    assert_holdoff_R3: assert property (@(posedge clk) disable iff (rst)
        !hold_expired |=> ceil_q >= $past(ceil_q));

    assert_idle_sample_R8: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable(ceil_q));

    assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (mult_changed == (mult_q != $past(mult_q))));

    assert_cold_snap_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && zone == ZONE_COLD && ceil_q < abs_max)
        |=> ceil_q == $past(abs_max));

endmodule

// File: tb/thermal_governor_test.sv
module thermal_governor_test;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 8;
    localparam int TW = 10;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_valid = 1'b0;
    logic [TW-1:0] sample_temp = '0;
    logic [TW-1:0] target_temp = '0;
    logic [TW-2:0] hysteresis = '0;
    logic [MW-1:0] abs_max = '0;
    logic [HW-1:0] holdoff_cycles = '0;
    logic          req_valid = 1'b0;
    logic [MW-1:0] req_mult = '0;
    logic [MW-1:0] mult_out, ceiling_out;
    logic          mult_changed;

    int checks = 0;
    int failures = 0;

    // reference model state
    int m_mult, m_ceil, m_since, m_hload;
    bit m_chg;
    int c_t, c_tg, c_h, c_amax, c_hold, c_req;
    bit c_sv, c_rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_governor uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .sample_temp(sample_temp), .target_temp(target_temp),
        .hysteresis(hysteresis), .abs_max(abs_max),
        .holdoff_cycles(holdoff_cycles), .req_valid(req_valid),
        .req_mult(req_mult), .mult_out(mult_out),
        .ceiling_out(ceiling_out), .mult_changed(mult_changed)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance the reference model by one clock edge, from the requirements
    task automatic model_edge();
        int prev;
        prev = m_mult;
        m_since++;
        if (c_sv) begin
            if (c_t > c_tg + c_h) begin
                if (m_since >= m_hload + 1) begin
                    if (m_mult > 1) m_mult--;
                    m_ceil  = m_mult;
                    m_since = 0;
                    m_hload = c_hold;
                end
            end else if (m_ceil < c_amax && c_t < c_tg) begin
                if (c_t < c_tg - c_h) m_ceil = c_amax;
                else if (m_mult == m_ceil) m_ceil++;
            end
        end else if (c_rv) begin
            m_mult = (c_req < 1) ? 1 : ((c_req > m_ceil) ? m_ceil : c_req);
        end
        m_chg = (m_mult != prev);
    endtask

    task automatic cycle(input bit sv, input int t, input bit rv, input int rq);
        c_sv = sv; c_t = t; c_rv = rv; c_req = rq;
        sample_valid = sv;
        sample_temp  = TW'(t);
        req_valid    = rv;
        req_mult     = MW'(rq);
        target_temp  = TW'(c_tg);
        hysteresis   = (TW-1)'(c_h);
        abs_max      = MW'(c_amax);
        holdoff_cycles = HW'(c_hold);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R9_mult", int'(mult_out), m_mult);
        check("R6_ceil", int'(ceiling_out), m_ceil);
        check("R11_pulse", int'(mult_changed), int'(m_chg));
        check("R12_order", int'(mult_out <= ceiling_out), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        c_tg = 70; c_h = 3; c_amax = 125; c_hold = 4;
        m_mult = 95; m_ceil = 125; m_since = 0; m_hload = 0; m_chg = 0;
        target_temp = TW'(c_tg);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1_mult", int'(mult_out), 95);
        check("R1_ceil", int'(ceiling_out), 125);
        check("R1_pulse", int'(mult_changed), 0);

        // R2: first hot sample reduces at once (hold-off expired from reset)
        cycle(1, 80, 0, 0);
        check("R2_mult", int'(mult_out), 94);
        check("R2_ceil", int'(ceiling_out), 94);
        check("R11_rise", int'(mult_changed), 1);
        // R3: four hot samples inside the hold-off window
        for (int i = 0; i < 4; i++) cycle(1, 80, 0, 0);
        check("R3_blocked", int'(mult_out), 94);
        check("R11_fall", int'(mult_changed), 0);
        cycle(1, 80, 0, 0);
        check("R3_release", int'(mult_out), 93);
        // R7: neutral zone, upper edge included
        cycle(1, 73, 0, 0);
        cycle(1, 70, 0, 0);
        check("R7_ceil", int'(ceiling_out), 93);
        // R6: band creep only while at the ceiling
        cycle(1, 67, 0, 0);
        check("R6_creep", int'(ceiling_out), 94);
        cycle(1, 69, 0, 0);
        check("R6_hold", int'(ceiling_out), 94);
        // R8: invalid cold sample ignored
        cycle(0, 20, 0, 0);
        check("R8_ceil", int'(ceiling_out), 94);
        // R5: cold snap
        cycle(1, 66, 0, 0);
        check("R5_snap", int'(ceiling_out), 125);
        // R9: clamping
        cycle(0, 0, 1, 200);
        check("R9_high", int'(mult_out), 125);
        cycle(0, 0, 1, 0);
        check("R9_low", int'(mult_out), 1);
        cycle(0, 0, 1, 50);
        check("R9_pass", int'(mult_out), 50);
        // R10: request dropped when a sample coincides
        cycle(1, 71, 1, 10);
        check("R10_drop", int'(mult_out), 50);
        // R4: floor
        cycle(0, 0, 1, 1);
        for (int i = 0; i < 5; i++) cycle(0, 0, 0, 0);
        cycle(1, 90, 0, 0);
        check("R4_floor", int'(mult_out), 1);
        check("R4_ceil", int'(ceiling_out), 1);
        cycle(0, 0, 1, 9);
        check("R12_clamp", int'(mult_out), 1);

        // random phase
        for (int seg = 0; seg < 30; seg++) begin
            c_h    = int'($urandom_range(0, 5));
            c_hold = int'($urandom_range(0, 6));
            c_amax = int'($urandom_range(100, 125));
            c_tg   = int'($urandom_range(0, 1)) ? 70 : -5;
            for (int k = 0; k < 100; k++) begin
                int t;
                bit sv, rv;
                t  = c_tg + int'($urandom_range(0, 24)) - 12;
                sv = ($urandom_range(0, 1) == 1);
                rv = ($urandom_range(0, 7) == 0);
                cycle(sv, t, rv, int'($urandom_range(0, 140)));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule